// File: doc/BRIEF.md
# PLL Feedback Divider with Optional Halving Stage

This block is the programmable feedback divider of a frequency synthesizer. It counts cycles of the high-rate input clock and emits one single-cycle pulse for every N counted cycles. That pulse stream goes to the phase comparator. N is a 17-bit unsigned ratio. An optional halving stage in front of the counter lets the counter advance only on every second input cycle, which doubles the overall ratio and the synthesizer step size.

Software writes a new ratio and a halving choice on the ratio and mode inputs, then pulses a commit strobe. The block stores the committed pair in a shadow register and applies it only when the output cycle in progress finishes, so the output period never takes an intermediate value. A ratio below the legal floor is raised to that floor, and a sticky flag reports the bad request.

For test, the port-zero output can carry the divider output divided by two in place of its programmed level.

Top module: `pll_fb_divider`

## Requirements
- R1: While synchronous reset is high, `div_pulse`, `range_err` and the half-rate monitor all read 0. After reset the active ratio is 64 with halving off, the counter starts at zero on the first clock after release, and the first pulse is seen 64 input cycles after release.
- R2: With halving off and active ratio N, `div_pulse` is high for exactly one input cycle and repeats every N input cycles.
- R3: With halving on and active ratio N, `div_pulse` repeats every 2N input cycles.
- R4: A `commit` captures `ratio_in` and `presc_en`. The new pair takes effect only at the terminal edge that ends the current output cycle, and that cycle keeps its old length. A commit sampled on a terminal edge takes effect one output cycle later.
- R5: Changing `ratio_in` or `presc_en` without `commit` has no effect on the output period.
- R6: A committed ratio below 64 is used as 64 and sets `range_err`. The next commit of a ratio of 64 or more clears `range_err`.
- R7: With `test_sel` = 1, `p0_out` carries a monitor that toggles on every output pulse, so it runs at half the pulse rate, and `p0_prog` is ignored.
- R8: With `test_sel` = 0, `p0_out` equals `p0_prog`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | High-rate input clock to be divided |
| rst | input | 1 | Synchronous reset, active high |
| ratio_in | input | 17 | Requested division ratio N |
| presc_en | input | 1 | Requested halving stage enable (1 = ratio doubled) |
| commit | input | 1 | One-cycle strobe that captures ratio_in and presc_en |
| test_sel | input | 1 | Selects the half-rate monitor onto p0_out |
| p0_prog | input | 1 | Programmed level of port bit zero |
| div_pulse | output | 1 | One-cycle pulse per completed division |
| p0_out | output | 1 | Port bit zero: programmed level or half-rate monitor |
| range_err | output | 1 | Last committed ratio was below the floor |

## Verification
On every cycle, the assertions check four local facts. The pulse is one cycle wide. The counter never passes the active terminal value. The active ratio moves only on a terminal edge. The halving stage never allows two counter steps in a row. They also check that the monitor flips exactly on terminal edges and that a low commit raises the error flag. The output periods themselves can only be shown by the bench's scenarios, since they span many cycles and depend on the parameters. Those scenarios cover the length of the cycle in which a commit lands, a commit that coincides with the terminal edge, the clamped ratio and the doubled period.

// File: rtl/fbd_pkg.sv
package fbd_pkg;
  localparam int RATIO_W   = 17;
  localparam int MIN_RATIO = 64;

  typedef enum logic {
    STEP_EVERY = 1'b0,
    STEP_HALF  = 1'b1
  } step_mode_e;
endpackage

// File: rtl/fbd_ratio_shadow.sv
module fbd_ratio_shadow #(
  parameter int W       = fbd_pkg::RATIO_W,
  parameter int MIN_VAL = fbd_pkg::MIN_RATIO
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                commit,
  input  logic [W-1:0]        ratio_in,
  input  logic                presc_en,
  input  logic                load,
  output logic [W-1:0]        act_m1,
  output fbd_pkg::step_mode_e act_mode,
  output logic                range_err
);
  localparam logic [W-1:0] FLOOR = W'(MIN_VAL);

  function automatic logic [W-1:0] clamp_ratio(input logic [W-1:0] r);
    return (r < FLOOR) ? FLOOR : r;
  endfunction

  logic [W-1:0]        sh_m1;
  fbd_pkg::step_mode_e sh_mode;
  logic                pend;
  logic                low_req;

  assign low_req = (ratio_in < FLOOR);

  always_ff @(posedge clk) begin
    if (rst) begin
      sh_m1     <= FLOOR - 1'b1;
      sh_mode   <= fbd_pkg::STEP_EVERY;
      pend      <= 1'b0;
      act_m1    <= FLOOR - 1'b1;
      act_mode  <= fbd_pkg::STEP_EVERY;
      range_err <= 1'b0;
    end else begin
      if (load && pend) begin
        act_m1   <= sh_m1;
        act_mode <= sh_mode;
      end
      if (commit) begin
        sh_m1     <= clamp_ratio(ratio_in) - 1'b1;
        sh_mode   <= presc_en ? fbd_pkg::STEP_HALF : fbd_pkg::STEP_EVERY;
        range_err <= low_req;
        pend      <= 1'b1;
      end else if (load) begin
        pend <= 1'b0;
      end
    end
  end

  // R4: active ratio only moves on a terminal edge
  a_r4_hold_between_edges: assert property (@(posedge clk) disable iff (rst)
    !load |=> $stable(act_m1));
  // R6: low request raises the flag
  a_r6_low_flag: assert property (@(posedge clk) disable iff (rst)
    (commit && low_req) |=> range_err);
endmodule

// File: rtl/fbd_prescaler.sv
module fbd_prescaler (
  input  logic                clk,
  input  logic                rst,
  input  fbd_pkg::step_mode_e mode,
  input  logic                tc,
  output logic                adv
);
  logic phase_q;

  always_ff @(posedge clk) begin
    if (rst)                             phase_q <= 1'b0;
    else if (tc)                         phase_q <= 1'b0;
    else if (mode == fbd_pkg::STEP_HALF) phase_q <= ~phase_q;
    else                                 phase_q <= 1'b0;
  end

  assign adv = (mode == fbd_pkg::STEP_EVERY) || phase_q;

  // R3: halving stage never grants two steps in a row
  a_r3_no_back_to_back: assert property (@(posedge clk) disable iff (rst)
    (mode == fbd_pkg::STEP_HALF && adv) |=> (!adv || mode == fbd_pkg::STEP_EVERY));
endmodule

// File: rtl/fbd_counter.sv
module fbd_counter #(
  parameter int W = fbd_pkg::RATIO_W
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         adv,
  input  logic [W-1:0] act_m1,
  output logic         tc,
  output logic         div_pulse
);
  logic [W-1:0] cnt;

  assign tc = adv && (cnt == act_m1);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt       <= '0;
      div_pulse <= 1'b0;
    end else begin
      div_pulse <= tc;
      if (tc)       cnt <= '0;
      else if (adv) cnt <= cnt + 1'b1;
    end
  end

  // R2: counter never passes the terminal value
  a_r2_count_bound: assert property (@(posedge clk) disable iff (rst)
    cnt <= act_m1);
  // R2: output pulse is one input cycle wide
  a_r2_single_pulse: assert property (@(posedge clk) disable iff (rst)
    div_pulse |=> !div_pulse);
endmodule

// File: rtl/fbd_monitor.sv
module fbd_monitor (
  input  logic clk,
  input  logic rst,
  input  logic tc,
  input  logic test_sel,
  input  logic p0_prog,
  output logic p0_out
);
  logic mon_q;

  always_ff @(posedge clk) begin
    if (rst)     mon_q <= 1'b0;
    else if (tc) mon_q <= ~mon_q;
  end

  assign p0_out = test_sel ? mon_q : p0_prog;

  // R7: monitor flips on each terminal edge and holds otherwise
  a_r7_flip_on_tc: assert property (@(posedge clk) disable iff (rst)
    tc |=> (mon_q != $past(mon_q)));
  a_r7_hold_off_tc: assert property (@(posedge clk) disable iff (rst)
    !tc |=> $stable(mon_q));
endmodule

// File: rtl/pll_fb_divider.sv
module pll_fb_divider #(
  parameter int RATIO_W   = fbd_pkg::RATIO_W,
  parameter int MIN_RATIO = fbd_pkg::MIN_RATIO
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [RATIO_W-1:0] ratio_in,
  input  logic               presc_en,
  input  logic               commit,
  input  logic               test_sel,
  input  logic               p0_prog,
  output logic               div_pulse,
  output logic               p0_out,
  output logic               range_err
);
  logic [RATIO_W-1:0]  act_m1;
  fbd_pkg::step_mode_e act_mode;
  logic                adv;
  logic                tc;

  fbd_ratio_shadow #(.W(RATIO_W), .MIN_VAL(MIN_RATIO)) u_shadow (
    .clk(clk), .rst(rst), .commit(commit), .ratio_in(ratio_in),
    .presc_en(presc_en), .load(tc), .act_m1(act_m1),
    .act_mode(act_mode), .range_err(range_err)
  );

  fbd_prescaler u_pre (
    .clk(clk), .rst(rst), .mode(act_mode), .tc(tc), .adv(adv)
  );

  fbd_counter #(.W(RATIO_W)) u_cnt (
    .clk(clk), .rst(rst), .adv(adv), .act_m1(act_m1),
    .tc(tc), .div_pulse(div_pulse)
  );

  fbd_monitor u_mon (
    .clk(clk), .rst(rst), .tc(tc), .test_sel(test_sel),
    .p0_prog(p0_prog), .p0_out(p0_out)
  );
endmodule

// File: tb/pll_fb_divider_bench.sv
module pll_fb_divider_bench;
  localparam int CLK_P   = 10;
  localparam int GAP_MAX = 3000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [16:0] ratio_in = '0;
  logic        presc_en = 1'b0;
  logic        commit = 1'b0;
  logic        test_sel = 1'b0;
  logic        p0_prog = 1'b0;
  logic        div_pulse, p0_out, range_err;

  int checks = 0;
  int fails  = 0;

  always #(CLK_P/2) clk = ~clk;

  pll_fb_divider u_pll_fb_divider (
    .clk(clk), .rst(rst), .ratio_in(ratio_in), .presc_en(presc_en),
    .commit(commit), .test_sel(test_sel), .p0_prog(p0_prog),
    .div_pulse(div_pulse), .p0_out(p0_out), .range_err(range_err)
  );

  function automatic int exp_period(input int n, input bit pe);
    int eff;
    eff = (n < 64) ? 64 : n;
    return pe ? 2 * eff : eff;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  // Counts negedges until div_pulse is seen. cat=0 raises commit before the
  // first edge, cat>0 raises it at that negedge, cat<0 never.
  task automatic next_gap(input int cat, output int g);
    g = 0;
    if (cat == 0) commit = 1'b1;
    do begin
      @(negedge clk);
      g++;
      commit = 1'b0;
      if (g == cat) commit = 1'b1;
    end while (!div_pulse && g < GAP_MAX);
  endtask

  task automatic summary;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
  endtask

  initial begin
    #(CLK_P * 150000);
    fails++;
    $display("FAIL watchdog expired");
    summary();
    $finish;
  end

  initial begin
    int g;
    int cur;
    void'($urandom(32'h00C0FFEE));
    test_sel = 1'b1;
    repeat (3) @(negedge clk);
    check(div_pulse == 1'b0, "R1 pulse in reset", div_pulse, 0);
    check(p0_out == 1'b0, "R1 monitor in reset", p0_out, 0);
    check(range_err == 1'b0, "R1 flag in reset", range_err, 0);
    test_sel = 1'b0;
    rst = 1'b0;
    next_gap(-1, g);
    check(g == 64, "R1 first pulse", g, 64);
    @(negedge clk);
    check(div_pulse == 1'b0, "R2 pulse width", div_pulse, 0);
    next_gap(-1, g);
    check(g == 63, "R2 period 64 (after width sample)", g + 1, 64);

    // R4: commit mid-cycle keeps current length
    ratio_in = 17'd100; presc_en = 1'b0;
    next_gap(0, g);
    check(g == 64, "R4 current cycle kept", g, 64);
    next_gap(-1, g);
    check(g == 100, "R2 period 100", g, 100);

    // R5: no commit, no change
    ratio_in = 17'd300; presc_en = 1'b1;
    next_gap(-1, g);
    check(g == 100, "R5 uncommitted ignored", g, 100);

    // R3: halving
    ratio_in = 17'd70; presc_en = 1'b1;
    next_gap(0, g);
    check(g == 100, "R4 old cycle before halving", g, 100);
    next_gap(-1, g);
    check(g == 140, "R3 doubled period", g, 140);

    // R4: commit on the terminal edge waits one more cycle
    ratio_in = 17'd90; presc_en = 1'b0;
    next_gap(139, g);
    check(g == 140, "R4 terminal-edge commit cycle", g, 140);
    next_gap(-1, g);
    check(g == 140, "R4 terminal-edge commit deferred", g, 140);
    next_gap(-1, g);
    check(g == 90, "R4 deferred value applied", g, 90);

    // R6: clamp
    ratio_in = 17'd5; presc_en = 1'b0;
    next_gap(0, g);
    check(g == 90, "R6 old cycle", g, 90);
    check(range_err == 1'b1, "R6 flag set", range_err, 1);
    next_gap(-1, g);
    check(g == 64, "R6 clamped period", g, 64);
    ratio_in = 17'd80;
    next_gap(0, g);
    check(range_err == 1'b0, "R6 flag cleared", range_err, 0);
    next_gap(-1, g);
    check(g == 80, "R2 period 80", g, 80);
    cur = 80;

    // Random commits at random offsets
    for (int i = 0; i < 10; i++) begin
      int n;
      bit pe;
      int cat;
      int nxt;
      n   = int'($urandom % 400);
      pe  = 1'($urandom % 2);
      cat = int'($urandom % cur);
      if (i == 3) cat = cur - 1;
      nxt = exp_period(n, pe);
      ratio_in = n[16:0]; presc_en = pe;
      next_gap(cat, g);
      check(g == cur, "R4 random old cycle", g, cur);
      if (cat == cur - 1) begin
        next_gap(-1, g);
        check(g == cur, "R4 random terminal commit", g, cur);
      end
      next_gap(-1, g);
      check(g == nxt, pe ? "R3 random period" : "R2 random period", g, nxt);
      check(range_err == (n < 64), "R6 random flag", range_err, int'(n < 64));
      cur = nxt;
    end

    // R7/R8: test mode
    test_sel = 1'b1;
    next_gap(-1, g);
    begin
      logic prev;
      prev = p0_out;
      p0_prog = ~prev;
      @(negedge clk);
      check(p0_out == prev, "R7 p0_prog ignored", p0_out, prev);
      next_gap(-1, g);
      check(p0_out == ~prev, "R7 monitor toggles", p0_out, ~prev);
      next_gap(-1, g);
      check(p0_out == prev, "R7 monitor toggles back", p0_out, prev);
    end
    test_sel = 1'b0; p0_prog = 1'b1;
    @(negedge clk);
    check(p0_out == 1'b1, "R8 programmed high", p0_out, 1);
    p0_prog = 1'b0;
    @(negedge clk);
    check(p0_out == 1'b0, "R8 programmed low", p0_out, 0);

    summary();
    $finish;
  end
endmodule